// File: doc/BRIEF.md
# Interrupt Identification and Dispatch Unit

This unit sits between a set of peripheral interrupt sources and a CPU core. Each peripheral presents several interrupt flags, and each flag has its own enable bit. The unit collapses every peripheral's enabled flags into one identification bit. It then arranges those bits into three read-only identification words that software can inspect to find the requester.

In parallel, the unit registers the combined request on every rising clock edge. A small sequencer turns that sampled request into a service sequence, which works like a hardware-issued long call:

- It announces the take with a one-cycle pulse and drops the global enable.
- It waits for the executing instruction to retire. It waits for one more instruction when that instruction opened an exception window.
- It asks for the return address to be pushed.
- It strobes a load of the program counter from the programmable vector register.

All pins are plain control and status signals. No data stream passes through the unit, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_dispatch`

## Requirements
- R1: Each identification bit is the OR, over the four sources of its peripheral, of (flag AND enable). Source s of peripheral p is bit p*4+s of `src_flag` and of `src_en`.
- R2: Word A (`id_word_a`) layout:
  - bits 0..6 are external pins 0..6 (peripherals 0..6);
  - bit 7 is the I2C master (peripheral 7);
  - bit 8 is the supply monitor (peripheral 8);
  - bits 9..15 read 0.
- R3: Word B (`id_word_b`) layout:
  - bit 0 is the ADC (peripheral 9);
  - bit 1 is the 3-wire block (peripheral 10);
  - bit 2 is the first SPI slave (peripheral 11);
  - all other bits read 0.

  Word C (`id_word_c`) layout:
  - bit 0 is the second SPI slave (peripheral 12);
  - bit 1 is the fast comparator (peripheral 13);
  - all other bits read 0.
- R4: Requests are sampled on the rising edge. `irq_take` is first high in the cycle after the one in which an enabled flag was high, and never in that same cycle.
- R5: While `gie` is 0 no take occurs. A take clears `gie` on the next edge. A write with `gie_wr`=1 loads `gie_wdata`, except in a take cycle, where the clear wins.
- R6: With `excp_win` low in the sampling cycle, `push_req` rises in the cycle after the first `instr_done` strobe seen after the take.
- R7: With `excp_win` high in the sampling cycle, two `instr_done` strobes are needed after the take. The first strobe does not raise `push_req`.
- R8: `push_req` is high for exactly one cycle. `load_pc` is high for exactly the following cycle. `vec_addr` equals the vector register.
- R9: The vector register resets to 0 and loads `vec_wdata` on the edge where `vec_wr` is 1.
- R10: A flag whose enable bit is 0 changes neither the identification words nor `irq_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | 56 | Per-source interrupt flags, four per peripheral |
| src_en | input | 56 | Per-source enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| gie | output | 1 | Current global enable |
| vec_wr | input | 1 | Write strobe for the vector register |
| vec_wdata | input | 16 | Value written to the vector register |
| excp_win | input | 1 | Executing instruction opens an exception window |
| instr_done | input | 1 | Instruction-complete strobe |
| id_word_a | output | 16 | Identification word A |
| id_word_b | output | 16 | Identification word B |
| id_word_c | output | 16 | Identification word C |
| irq_take | output | 1 | One-cycle interrupt-take pulse |
| push_req | output | 1 | Request to push the return address |
| load_pc | output | 1 | Strobe to load the PC from `vec_addr` |
| vec_addr | output | 16 | Interrupt vector address |

## Verification
The assertions assume two things about the core's inputs:
- `instr_done` is a strobe that the core raises only while an instruction retires.
- `excp_win` is meaningful in the cycle in which the request is sampled.

The stimulus honours both. It raises `excp_win` only in the cycle in which a flag first appears, and it pulses `instr_done` for a single cycle with random gaps while a service is pending. It also keeps `gie` at 0 during the random identification-word phase, so that no service starts while the flag pattern changes every cycle.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

  localparam int N_PERIPH = 14;
  localparam int N_IDWORD = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PUSH,
    ST_VECTOR
  } seq_state_t;

  // identification word that carries peripheral p
  function automatic int word_of(input int p);
    if (p <= 8) return 0;
    if (p <= 11) return 1;
    return 2;
  endfunction

  // bit position of peripheral p inside its word
  function automatic int bit_of(input int p);
    if (p <= 8) return p;
    if (p <= 11) return p - 9;
    return p - 12;
  endfunction

  // which peripherals land on word w, bit b
  function automatic logic [N_PERIPH-1:0] slot_mask(input int w, input int b);
    logic [N_PERIPH-1:0] m;
    m = '0;
    for (int p = 0; p < N_PERIPH; p++)
      if (word_of(p) == w && bit_of(p) == b) m[p] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_id_reduce.sv
module irq_id_reduce #(
  parameter int N_PERIPH = 14,
  parameter int SRC_PER  = 4
) (
  input  logic [N_PERIPH*SRC_PER-1:0] flag,
  input  logic [N_PERIPH*SRC_PER-1:0] en,
  output logic [N_PERIPH-1:0]         hit
);
  for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
    assign hit[p] = |(flag[p*SRC_PER +: SRC_PER] & en[p*SRC_PER +: SRC_PER]);
  end
endmodule

// File: rtl/irq_id_pack.sv
module irq_id_pack
  import irq_disp_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic [N_PERIPH-1:0]      hit,
  output logic [N_IDWORD*ID_W-1:0] words
);
  for (genvar w = 0; w < N_IDWORD; w++) begin : g_word
    for (genvar b = 0; b < ID_W; b++) begin : g_bit
      localparam logic [N_PERIPH-1:0] MASK = slot_mask(w, b);
      assign words[w*ID_W + b] = |(hit & MASK);
    end
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_disp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic excp_win,
  input  logic instr_done,
  input  logic gie,
  output logic take,
  output logic push_req,
  output logic load_pc
);
  seq_state_t state_q;
  logic [1:0] need_q;
  logic       req_q;
  logic       win_q;

  assign take     = (state_q == ST_IDLE) && req_q && gie;
  assign push_req = (state_q == ST_PUSH);
  assign load_pc  = (state_q == ST_VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      need_q  <= '0;
      req_q   <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      req_q <= req_any;
      win_q <= excp_win;
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_WAIT;
          need_q  <= win_q ? 2'd2 : 2'd1;
        end
        ST_WAIT: if (instr_done) begin
          need_q <= need_q - 2'd1;
          if (need_q == 2'd1) state_q <= ST_PUSH;
        end
        ST_PUSH:   state_q <= ST_VECTOR;
        ST_VECTOR: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_take_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> gie);
  a_r6_push_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_req) |-> $past(instr_done));
  a_r8_push_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> (load_pc && !push_req));
  a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_pc |=> !load_pc);
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, push_req, load_pc}));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int SRC_PER = 4,
  parameter int ID_W    = 16,
  parameter int VEC_W   = 16,
  localparam int N_SRC  = N_PERIPH * SRC_PER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie_wr,
  input  logic             gie_wdata,
  output logic             gie,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             excp_win,
  input  logic             instr_done,
  output logic [ID_W-1:0]  id_word_a,
  output logic [ID_W-1:0]  id_word_b,
  output logic [ID_W-1:0]  id_word_c,
  output logic             irq_take,
  output logic             push_req,
  output logic             load_pc,
  output logic [VEC_W-1:0] vec_addr
);
  logic [N_PERIPH-1:0]      hit;
  logic [N_IDWORD*ID_W-1:0] words;
  logic                     gie_q;
  logic [VEC_W-1:0]         vec_q;

  irq_id_reduce #(.N_PERIPH(N_PERIPH), .SRC_PER(SRC_PER)) u_reduce (
    .flag(src_flag), .en(src_en), .hit(hit)
  );

  irq_id_pack #(.ID_W(ID_W)) u_pack (
    .hit(hit), .words(words)
  );

  irq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req_any(|hit), .excp_win(excp_win),
    .instr_done(instr_done), .gie(gie_q), .take(irq_take),
    .push_req(push_req), .load_pc(load_pc)
  );

  assign id_word_a = words[0*ID_W +: ID_W];
  assign id_word_b = words[1*ID_W +: ID_W];
  assign id_word_c = words[2*ID_W +: ID_W];
  assign gie       = gie_q;
  assign vec_addr  = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (irq_take)    gie_q <= 1'b0;
      else if (gie_wr) gie_q <= gie_wdata;
      if (vec_wr) vec_q <= vec_wdata;
    end
  end

  a_r4_take_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(|src_flag & |src_en));
  a_r5_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !gie);
  a_r9_vector_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    vec_wr |=> (vec_addr == $past(vec_wdata)));
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int NP = 14;
  localparam int SP = 4;
  localparam int NS = NP * SP;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_flag, src_en;
  logic          gie_wr, gie_wdata, gie;
  logic          vec_wr;
  logic [15:0]   vec_wdata;
  logic          excp_win, instr_done;
  logic [15:0]   id_word_a, id_word_b, id_word_c, vec_addr;
  logic          irq_take, push_req, load_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_vec = '0;

  always #10 clk = ~clk;

  irq_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .gie(gie),
    .vec_wr(vec_wr), .vec_wdata(vec_wdata), .excp_win(excp_win),
    .instr_done(instr_done), .id_word_a(id_word_a), .id_word_b(id_word_b),
    .id_word_c(id_word_c), .irq_take(irq_take), .push_req(push_req),
    .load_pc(load_pc), .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected identification words from requirement R1..R3
  function automatic logic [47:0] exp_words(input logic [NS-1:0] f, input logic [NS-1:0] e);
    logic [NP-1:0] h;
    logic [15:0] a, b, c;
    for (int p = 0; p < NP; p++) h[p] = |(f[p*SP +: SP] & e[p*SP +: SP]);
    a = {7'd0, h[8:0]};
    b = {13'd0, h[11], h[10], h[9]};
    c = {14'd0, h[13], h[12]};
    return {c, b, a};
  endfunction

  task automatic check_ids(input string req);
    logic [47:0] w;
    w = exp_words(src_flag, src_en);
    chk(req, {16'd0, id_word_a}, {16'd0, w[15:0]});
    chk(req, {16'd0, id_word_b}, {16'd0, w[31:16]});
    chk(req, {16'd0, id_word_c}, {16'd0, w[47:32]});
  endtask

  task automatic set_gie(input logic v);
    @(negedge clk); gie_wr = 1'b1; gie_wdata = v;
    @(negedge clk); gie_wr = 1'b0;
  endtask

  task automatic write_vec(input logic [15:0] v);
    @(negedge clk); vec_wr = 1'b1; vec_wdata = v;
    @(negedge clk); vec_wr = 1'b0; exp_vec = v;
    chk("R9 vector write", {16'd0, vec_addr}, {16'd0, v});
  endtask

  // full service sequence for source s of peripheral p
  task automatic serve(input int p, input int s, input logic win);
    int need;
    @(negedge clk); src_flag = '0; src_en = '1; gie_wr = 1'b1; gie_wdata = 1'b1;
    @(negedge clk); gie_wr = 1'b0;
    src_flag[p*SP + s] = 1'b1; excp_win = win;
    chk("R4 no take in sampling cycle", {31'd0, irq_take}, 32'd0);
    @(negedge clk); excp_win = 1'b0;
    chk("R4 take one cycle later", {31'd0, irq_take}, 32'd1);
    @(negedge clk);
    chk("R5 take clears gie", {31'd0, gie}, 32'd0);
    chk("R4 take is a pulse", {31'd0, irq_take}, 32'd0);
    need = win ? 2 : 1;
    for (int k = 0; k < need; k++) begin
      int gap;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R6 no push before done", {31'd0, push_req}, 32'd0);
      end
      instr_done = 1'b1;
      @(negedge clk); instr_done = 1'b0;
      if (k == need - 1)
        chk(win ? "R7 push after second done" : "R6 push after done", {31'd0, push_req}, 32'd1);
      else
        chk("R7 first done gives no push", {31'd0, push_req}, 32'd0);
    end
    @(negedge clk);
    chk("R8 load after push", {31'd0, load_pc}, 32'd1);
    chk("R8 push single cycle", {31'd0, push_req}, 32'd0);
    chk("R8 vector address", {16'd0, vec_addr}, {16'd0, exp_vec});
    @(negedge clk);
    chk("R8 load single cycle", {31'd0, load_pc}, 32'd0);
    chk("R5 no re-entry while gie clear", {31'd0, irq_take}, 32'd0);
    src_flag = '0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4117));
    rst_n = 1'b0; src_flag = '0; src_en = '0; gie_wr = 1'b0; gie_wdata = 1'b0;
    vec_wr = 1'b0; vec_wdata = '0; excp_win = 1'b0; instr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset gie", {31'd0, gie}, 32'd0);
    chk("R9 reset vector", {16'd0, vec_addr}, 32'd0);
    chk("R8 reset strobes", {29'd0, irq_take, push_req, load_pc}, 32'd0);
    check_ids("R1 reset ids");

    // R2 R3 every source set and enabled
    src_flag = '1; src_en = '1; #5;
    chk("R2 word A layout", {16'd0, id_word_a}, 32'h01FF);
    chk("R3 word B layout", {16'd0, id_word_b}, 32'h0007);
    chk("R3 word C layout", {16'd0, id_word_c}, 32'h0003);
    // R10 disabled flags are ignored
    @(negedge clk); src_en = '0; gie_wr = 1'b1; gie_wdata = 1'b1;
    @(negedge clk); gie_wr = 1'b0; #5;
    check_ids("R10 disabled ids");
    @(negedge clk);
    chk("R10 disabled no take", {31'd0, irq_take}, 32'd0);
    @(negedge clk);
    chk("R10 disabled no take", {31'd0, irq_take}, 32'd0);
    src_flag = '0;
    set_gie(1'b0);

    // R5 enabled flag with gie clear
    @(negedge clk); src_en = '1; src_flag[7*SP + 2] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R5 no take while gie clear", {31'd0, irq_take}, 32'd0);
    end
    src_flag = '0;
    @(negedge clk);

    // R1 R10 random flags and enables with gie clear
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      src_flag = {$urandom, $urandom};
      src_en   = {$urandom, $urandom};
      #5;
      check_ids("R1 random ids");
      chk("R5 no take while gie clear", {31'd0, irq_take}, 32'd0);
    end
    @(negedge clk); src_flag = '0; src_en = '0;

    write_vec(16'h01A2);
    serve(0, 0, 1'b0);
    serve(13, 3, 1'b1);
    for (int i = 0; i < 30; i++) begin
      if (i % 5 == 0) write_vec(16'($urandom));
      serve($urandom_range(0, NP - 1), $urandom_range(0, SP - 1), 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule